// File: doc/BRIEF.md
# Fractional-Rate Sample Decimator

This block accepts one signed sample on every clock and emits a lower-rate stream at a ratio that need not be an integer. The ratio is the number of input clocks per output sample, given as an unsigned fixed-point value with 10 fractional bits. For example, 2.718 clocks per sample is written as 2783. A countdown counter and a 10-bit fraction track where each output falls between input samples.

Two modes select how an output value is formed. In nearest mode the phase carries a half-cycle bias, and the output is the input sample closest to the output instant. In blend mode the two most recent input samples are mixed linearly, weighted by the fraction. In both modes the result saturates to the narrower output width. A strobe marks each new output for one clock.

Top module: `frac_decimator`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 and `out_sample` is 0 until the first output is produced.
- R2: `ratio` is unsigned with 10 fractional bits. Any value below 1024 acts as exactly 1024, so one output is produced per input clock.
- R3: Input samples are numbered k = 0, 1, 2, … starting at the first rising edge after reset is released. In nearest mode the phase starts at 0. The next position is phase + step + 512, and its integer part (position >> 10) is the number of input clocks to the next output. An output for sample index N is valid just after edge N.
- R4: In nearest mode, after each output the phase becomes (position & 1023) − 512.
- R5: In nearest mode the output value is the input sample at the output index, saturated to the output width.
- R6: In blend mode the phase advances by the step alone. Its fraction (position & 1023) is kept as both the blend weight and the start of the next interval.
- R7: In blend mode the output is prev + ((frac × (now − prev)) >>> 10). The shift is arithmetic, so a negative difference rounds toward minus infinity.
- R8: In blend mode, "now" is the sample at the output index and "prev" is the sample one clock earlier.
- R9: The output saturates to the signed range of OUT_W bits: at most 32767 and at least −32768 for the default width.
- R10: `out_valid` is high for exactly one clock per produced sample. `out_sample` holds its value between outputs.
- R11: The ratio is sampled only at an output boundary. A change made just after an output first alters the interval that begins at the next output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one input sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sample | input | IN_W (18) | Signed input sample |
| ratio | input | RATIO_W (32) | Clocks per output sample, 10 fractional bits |
| mode | input | 1 | 0 = nearest sample, 1 = linear blend |
| out_sample | output | OUT_W (16) | Signed, saturated output sample |
| out_valid | output | 1 | One-clock strobe for each new output |

## Verification
The value that goes with input index N is registered on edge N. So the strobe and the value are both due 1 ns after that edge, with no further delay. The bench advances its own copy of the phase arithmetic at each expected output, working only from the requirements. It then checks every clock: the strobe must be high on the predicted edge and low on all others. A ratio change is applied right after an observed output, and the bench charges it to the interval that starts at the following boundary.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
    localparam int FDEC_FRAC_W = 10;

    typedef enum logic {
        MODE_NEAREST = 1'b0,
        MODE_BLEND   = 1'b1
    } fdec_mode_e;
endpackage

// File: rtl/fdec_phase.sv
module fdec_phase
    import fdec_pkg::*;
#(
    parameter int RATIO_W = 32,
    parameter int FRAC_W  = FDEC_FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    input  fdec_mode_e         mode,
    output logic               fire,
    output logic [FRAC_W-1:0]  frac
);
    localparam int CNT_W = RATIO_W - FRAC_W + 1;
    localparam logic [RATIO_W-1:0] ONE_V  = RATIO_W'(1) << FRAC_W;
    localparam logic [FRAC_W-1:0]  HALF_V = FRAC_W'(1) << (FRAC_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  rem;
        logic [FRAC_W-1:0] frac;
        logic              first;
    } phase_t;

    phase_t s_q, s_d;

    logic               boundary;
    logic [RATIO_W-1:0] step;
    logic [FRAC_W-1:0]  base;
    logic [RATIO_W:0]   nxt;

    always_comb begin
        s_d      = s_q;
        step     = (ratio < ONE_V) ? ONE_V : ratio;
        boundary = s_q.first || (s_q.rem == CNT_W'(1));
        if (s_q.first) begin
            base = (mode == MODE_NEAREST) ? HALF_V : '0;
        end else begin
            base = s_q.frac;
        end
        nxt = {1'b0, step} + (RATIO_W + 1)'(base);
        if (boundary) begin
            s_d.rem   = nxt[RATIO_W:FRAC_W];
            s_d.frac  = nxt[FRAC_W-1:0];
            s_d.first = 1'b0;
        end else begin
            s_d.rem   = s_q.rem - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{rem: '0, frac: '0, first: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign fire = boundary && !s_q.first;
    assign frac = s_q.frac;

    assert_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.first |-> s_q.rem != '0);

    assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.first && s_q.rem > CNT_W'(1)) |=> s_q.rem == $past(s_q.rem) - CNT_W'(1));
endmodule

// File: rtl/fdec_blend.sv
module fdec_blend
    import fdec_pkg::*;
#(
    parameter int IN_W   = 18,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = FDEC_FRAC_W
) (
    input  logic [IN_W-1:0]   now,
    input  logic [IN_W-1:0]   prev,
    input  logic [FRAC_W-1:0] frac,
    input  fdec_mode_e        mode,
    output logic [OUT_W-1:0]  res
);
    localparam int PW    = IN_W + FRAC_W + 2;
    localparam int HI_I  = (1 << (OUT_W - 1)) - 1;
    localparam logic signed [PW-1:0] HI_V = PW'(HI_I);
    localparam logic signed [PW-1:0] LO_V = PW'(-HI_I - 1);

    logic signed [IN_W:0]  diff;
    logic signed [PW-1:0]  prod;
    logic signed [PW-1:0]  mix;
    logic signed [PW-1:0]  pick;
    logic signed [PW-1:0]  sat;

    always_comb begin
        diff = $signed({now[IN_W-1], now}) - $signed({prev[IN_W-1], prev});
        prod = PW'(diff) * PW'($signed({1'b0, frac}));
        mix  = PW'($signed(prev)) + (prod >>> FRAC_W);
        pick = (mode == MODE_NEAREST) ? PW'($signed(now)) : mix;
        if (pick > HI_V) begin
            sat = HI_V;
        end else if (pick < LO_V) begin
            sat = LO_V;
        end else begin
            sat = pick;
        end
        res = sat[OUT_W-1:0];
    end
endmodule

// File: rtl/frac_decimator.sv
module frac_decimator
    import fdec_pkg::*;
#(
    parameter int IN_W    = 18,
    parameter int OUT_W   = 16,
    parameter int RATIO_W = 32,
    parameter int FRAC_W  = FDEC_FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IN_W-1:0]    in_sample,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               mode,
    output logic [OUT_W-1:0]   out_sample,
    output logic               out_valid
);
    localparam int HI_I = (1 << (OUT_W - 1)) - 1;
    localparam logic signed [IN_W-1:0] HI_V = IN_W'(HI_I);
    localparam logic signed [IN_W-1:0] LO_V = IN_W'(-HI_I - 1);

    typedef struct packed {
        logic [IN_W-1:0]  prev;
        logic [OUT_W-1:0] out;
        logic             valid;
    } top_t;

    top_t s_q, s_d;

    fdec_mode_e        md;
    logic              fire;
    logic [FRAC_W-1:0] frac;
    logic [OUT_W-1:0]  blended;

    assign md = fdec_mode_e'(mode);

    fdec_phase #(.RATIO_W(RATIO_W), .FRAC_W(FRAC_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (ratio),
        .mode  (md),
        .fire  (fire),
        .frac  (frac)
    );

    fdec_blend #(.IN_W(IN_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_blend (
        .now  (in_sample),
        .prev (s_q.prev),
        .frac (frac),
        .mode (md),
        .res  (blended)
    );

    always_comb begin
        s_d       = s_q;
        s_d.prev  = in_sample;
        s_d.valid = fire;
        if (fire) begin
            s_d.out = blended;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_sample = s_q.out;
    assign out_valid  = s_q.valid;

    // Bounds of the two samples being blended, widened by the saturation limits.
    logic signed [IN_W-1:0] span_lo, span_hi, span_floor, span_ceil;
    logic                   in_fits;
    always_comb begin
        span_lo    = ($signed(in_sample) < $signed(s_q.prev)) ? $signed(in_sample) : $signed(s_q.prev);
        span_hi    = ($signed(in_sample) < $signed(s_q.prev)) ? $signed(s_q.prev) : $signed(in_sample);
        span_floor = (span_lo < HI_V) ? span_lo : HI_V;
        span_ceil  = (span_hi > LO_V) ? span_hi : LO_V;
        in_fits    = ($signed(in_sample) <= HI_V) && ($signed(in_sample) >= LO_V);
    end

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    assert_nearest_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == 1'b0 && $past(in_fits))
        |-> out_sample == $past(in_sample[OUT_W-1:0]));

    assert_blend_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode) == 1'b1)
        |-> (IN_W'($signed(out_sample)) >= $past(span_floor)
             && IN_W'($signed(out_sample)) <= $past(span_ceil)));
endmodule

// File: tb/frac_decimator_test.sv
`timescale 1ns/1ps
module frac_decimator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] in_sample = '0;
    logic [31:0] ratio = 32'd2048;
    logic        mode = 1'b0;
    logic [15:0] out_sample;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frac_decimator uut (
        .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .ratio(ratio),
        .mode(mode), .out_sample(out_sample), .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pat_val(input int pat, input int k);
        case (pat)
            0: return k * 37 - 500;
            1: return (k % 3 == 0) ? 120000 : ((k % 3 == 1) ? -120000 : 5000);
            2: return 3000 - k * 211;
            default: return ((k / 4) % 2 == 1) ? 9000 : -7000;
        endcase
    endfunction

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int eff(input int r);
        return (r < 1024) ? 1024 : r;
    endfunction

    // Reset, then run ncyc input clocks against a model of R3..R8, R10, R11.
    task automatic run_case(input bit md, input int r1, input int r2, input int chg_after,
                            input int pat, input int ncyc, input string tag);
        int ofs, tgt, nx, cur, outs, expv, p, q;
        bit ev;
        rst_n = 1'b0; mode = md; ratio = r1; in_sample = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_sample == 16'd0, "R1 sample in reset", int'($signed(out_sample)), 0);
        rst_n = 1'b1;
        cur = r1; ofs = 0; outs = 0;
        if (md == 1'b0) begin
            nx = ofs + eff(cur) + 512; tgt = nx >> 10; ofs = (nx & 1023) - 512;
        end else begin
            nx = ofs + eff(cur); tgt = nx >> 10; ofs = nx & 1023;
        end
        for (int k = 0; k < ncyc; k++) begin
            if (k > 0) @(negedge clk);
            in_sample = 18'(pat_val(pat, k));
            @(posedge clk);
            #1;
            ev = (k == tgt);
            check(out_valid == ev, {"R10/", tag, " strobe"}, int'(out_valid), int'(ev));
            if (ev) begin
                if (md == 1'b0) begin
                    expv = sat16(pat_val(pat, tgt));
                end else begin
                    p = pat_val(pat, tgt - 1);
                    q = pat_val(pat, tgt);
                    expv = sat16(p + ((ofs * (q - p)) >>> 10));
                end
                check(int'($signed(out_sample)) == expv, {tag, " value"},
                      int'($signed(out_sample)), expv);
                if (md == 1'b0) begin
                    nx = ofs + eff(cur) + 512; tgt = tgt + (nx >> 10); ofs = (nx & 1023) - 512;
                end else begin
                    nx = ofs + eff(cur); tgt = tgt + (nx >> 10); ofs = nx & 1023;
                end
                outs++;
                if (outs == chg_after) begin
                    cur = r2;
                    ratio = r2;
                end
            end
        end
    endtask

    task automatic t_reset();
        run_case(1'b0, 3072, 3072, -1, 0, 4, "R1");
    endtask

    task automatic t_nearest();
        run_case(1'b0, 2783, 2783, -1, 0, 60, "R3 R4 R5 nearest frac");
        run_case(1'b0, 3072, 3072, -1, 3, 40, "R3 R5 nearest int");
    endtask

    task automatic t_blend();
        run_case(1'b1, 2783, 2783, -1, 0, 60, "R6 R8 blend ramp");
        run_case(1'b1, 3500, 3500, -1, 2, 60, "R7 blend negative diff");
    endtask

    task automatic t_clamp();
        run_case(1'b0, 1900, 1900, -1, 1, 40, "R9 nearest clamp");
        run_case(1'b1, 1900, 1900, -1, 1, 40, "R9 blend clamp");
    endtask

    task automatic t_min_ratio();
        run_case(1'b0, 0, 0, -1, 0, 12, "R2 ratio zero nearest");
        run_case(1'b1, 700, 700, -1, 2, 12, "R2 ratio low blend");
    endtask

    task automatic t_retune();
        run_case(1'b0, 2783, 5632, 3, 0, 60, "R11 nearest retune");
        run_case(1'b1, 5632, 2300, 2, 2, 60, "R11 blend retune");
    endtask

    initial begin
        t_reset();
        t_nearest();
        t_blend();
        t_clamp();
        t_min_ratio();
        t_retune();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule